// File: doc/BRIEF.md
# SPI Control and Diagnosis Register

This block is a 16-bit serial slave for a supply-management chip. It takes a control word over a four-wire serial port and returns a diagnosis word at the same time. The serial pins are sampled by the system clock. On each falling serial-clock edge the incoming bit enters the shift register. On each rising edge the outgoing data line advances by one bit. The received word is applied when chip select returns high. The outgoing word is a snapshot of the status inputs, taken when chip select falls. The data output is enabled only while the block is selected.

The control word holds six tracker enables, a sleep bit, a reset-delay code, a watchdog window code, three watchdog enable bits and a trigger bit. The status word mixes live status bits with sticky ones. The sticky bits are a composite error flag, two cold-start indications and a watchdog error. Each sticky bit is cleared only after a completed frame has carried its value out. The composite error also drives a hardware error pin. Frames of more than 16 bits are supported, so several devices can share one chain. A frame sent as two 8-bit bursts under one chip-select low period works the same way.

Top module: `spi_diag_reg`

## Requirements
- R1: After reset the control state equals the word 0x4301: trackers off, no power-down, delay and window codes 00, watchdog enabled. In the same state the error pin is low and the data output is disabled.
- R2: The word is received LSB first. It is applied only when chip select rises. Tracker n enable is bit n+1 (n = 1..6). rst_dly = {bit11, bit10}. wd_time = {bit13, bit12}.
- R3: At the falling edge of chip select the status word is captured and bit 0 is driven at once. After each rising serial-clock edge, the next bit is driven, LSB first. The data output is enabled only while chip select is low.
- R4: The status word carries the following fields:
  - bit0: error
  - bit1: temperature warning
  - bits7:2: tracker status 1..6
  - bits9:8: warm-start flags 1 and 2 (0 = cold)
  - bit10: window closed
  - bits13:11: reset conditions 1..3
  - bit14: watchdog error
  - bit15: converter on
- R5: A frame with fewer than 16 falling clock edges leaves the control state unchanged.
- R6: In a frame longer than 16 bits, the last 16 bits received are applied. The data output repeats the input bits delayed by 16 clocks.
- R7: Bits 0, 8, 9 and 14 are latched and clear only after a completed frame has shifted them out. All other status bits follow their inputs live.
- R8: The error latch sets on any of these events:
  - a temperature warning
  - a watchdog error
  - a cold-start event
  - an enabled tracker that has not settled within SETTLE_CYC cycles of being enabled
- R9: The error pin equals the error latch and is cleared by a completed frame.
- R10: power_down is high only when control bit 8 is 0 and wake is low.
- R11: The watchdog is disabled only for bit0=0, bit9=1 and bit14=0.
- R12: Applying a word with bit 15 set gives a single-cycle wd_trig pulse.
- R13: Each tracker status bit is the tracker's settled input ANDed with its enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| spi_sclk | input | 1 | Serial clock, idle low |
| spi_cs_n | input | 1 | Active-low select |
| spi_mosi | input | 1 | Serial data in |
| spi_miso | output | 1 | Serial data out |
| spi_miso_oe | output | 1 | Output enable for the data-out pad |
| wake | input | 1 | Wake level; high blocks power-down |
| trk_ok | input | 6 | Tracker settled flags |
| temp_warn | input | 1 | Temperature prewarning |
| cold_evt | input | 2 | Cold-start events, rails 1 and 2 |
| win_closed | input | 1 | Watchdog closed-window state |
| rst_cond | input | 3 | Reset conditions of the three rails |
| wd_err | input | 1 | Watchdog error event |
| conv_on | input | 1 | Converter running |
| trk_en | output | 6 | Tracker enables |
| power_down | output | 1 | Shut-down request |
| rst_dly | output | 2 | Reset-delay code |
| wd_time | output | 2 | Watchdog window code |
| wd_en | output | 1 | Watchdog enable |
| wd_trig | output | 1 | Watchdog trigger pulse |
| err_flag | output | 1 | Latched error pin |

## Verification
The bench builds the block with SETTLE_CYC set to 40, not the default of one millisecond of clock cycles. With that value a tracker settle timeout happens within a short run. The error pin can then be seen to set from that timeout and clear after the next frame. The serial half period is eight system clocks. This leaves room for the two-stage pin sampling, and it allows 24-bit chained frames and 8-bit short frames to be checked against the exact bit positions.

// File: rtl/spi_diag_pkg.sv
package spi_diag_pkg;
   localparam int WORD_W = 16;
   localparam int N_TRK  = 6;
   localparam logic [WORD_W-1:0] CTRL_RST = 16'h4301;

   typedef struct packed {
      logic [N_TRK-1:0] trk_en;
      logic             sleep_n;
      logic [1:0]       rst_dly;
      logic [1:0]       wd_time;
      logic             wd_en;
      logic             trig;
   } ctrl_t;

   function automatic ctrl_t decode_ctrl(input logic [WORD_W-1:0] w);
      ctrl_t c;
      c.trk_en  = w[2 +: N_TRK];
      c.sleep_n = w[8];
      c.rst_dly = {w[11], w[10]};
      c.wd_time = {w[13], w[12]};
      c.wd_en   = !(!w[0] && w[9] && !w[14]);
      c.trig    = w[15];
      return c;
   endfunction
endpackage

// File: rtl/spi_diag_shift.sv
module spi_diag_shift #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         sclk,
   input  logic         cs_n,
   input  logic         mosi,
   input  logic [W-1:0] load_word,
   output logic         miso,
   output logic         miso_oe,
   output logic         load_pulse,
   output logic         apply_pulse,
   output logic [W-1:0] rx_word
);
   localparam int CNT_W = $clog2(W + 1);

   logic sclk_s1, sclk_s2, cs_s1, cs_s2, mosi_s1;
   logic sclk_rise, sclk_fall, cs_fall, cs_rise;
   logic [W-1:0] sreg;
   logic [CNT_W-1:0] cnt;
   logic do_q, oe_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_s1 <= 1'b0;
         sclk_s2 <= 1'b0;
         cs_s1   <= 1'b1;
         cs_s2   <= 1'b1;
         mosi_s1 <= 1'b0;
      end else begin
         sclk_s1 <= sclk;
         sclk_s2 <= sclk_s1;
         cs_s1   <= cs_n;
         cs_s2   <= cs_s1;
         mosi_s1 <= mosi;
      end
   end

   assign sclk_rise = sclk_s1 & ~sclk_s2;
   assign sclk_fall = ~sclk_s1 & sclk_s2;
   assign cs_fall   = cs_s2 & ~cs_s1;
   assign cs_rise   = ~cs_s2 & cs_s1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sreg <= '0;
         cnt  <= '0;
         do_q <= 1'b0;
         oe_q <= 1'b0;
      end else begin
         oe_q <= ~cs_s1;
         if (cs_fall) begin
            sreg <= load_word;
            do_q <= load_word[0];
            cnt  <= '0;
         end else if (!cs_s1) begin
            if (sclk_rise) do_q <= sreg[0];
            if (sclk_fall) begin
               sreg <= {mosi_s1, sreg[W-1:1]};
               if (cnt != CNT_W'(W)) cnt <= cnt + CNT_W'(1);
            end
         end
      end
   end

   assign load_pulse  = cs_fall;
   assign apply_pulse = cs_rise && (cnt == CNT_W'(W));
   assign rx_word     = sreg;
   assign miso        = do_q;
   assign miso_oe     = oe_q;
endmodule

// File: rtl/spi_diag_ctrl.sv
module spi_diag_ctrl
   import spi_diag_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              apply,
   input  logic [WORD_W-1:0] rx_word,
   input  logic              wake,
   output logic [N_TRK-1:0]  trk_en,
   output logic              power_down,
   output logic [1:0]        rst_dly,
   output logic [1:0]        wd_time,
   output logic              wd_en,
   output logic              wd_trig
);
   logic [WORD_W-1:0] word_q;
   logic              trig_q;
   ctrl_t             c;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q <= CTRL_RST;
         trig_q <= 1'b0;
      end else begin
         trig_q <= 1'b0;
         if (apply) begin
            word_q <= rx_word;
            trig_q <= rx_word[15];
         end
      end
   end

   always_comb c = decode_ctrl(word_q);

   assign trk_en     = c.trk_en;
   assign power_down = ~c.sleep_n & ~wake;
   assign rst_dly    = c.rst_dly;
   assign wd_time    = c.wd_time;
   assign wd_en      = c.wd_en;
   assign wd_trig    = trig_q & c.trig;
endmodule

// File: rtl/spi_diag_stat.sv
module spi_diag_stat
   import spi_diag_pkg::*;
#(
   parameter int SETTLE_CYC = 125000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              apply,
   input  logic [N_TRK-1:0]  trk_en,
   input  logic [N_TRK-1:0]  trk_ok,
   input  logic              temp_warn,
   input  logic [1:0]        cold_evt,
   input  logic              win_closed,
   input  logic [2:0]        rst_cond,
   input  logic              wd_err,
   input  logic              conv_on,
   output logic [WORD_W-1:0] status_word,
   output logic              err_flag
);
   localparam int TW = $clog2(SETTLE_CYC + 1);

   logic [N_TRK-1:0] timeout;
   logic             err_l, wderr_l, snap_err, snap_wd;
   logic [1:0]       cold_l, snap_cold;
   logic             err_set, clr;

   for (genvar i = 0; i < N_TRK; i++) begin : g_trk
      logic [TW-1:0] cnt;
      logic          done, to_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt  <= '0;
            done <= 1'b0;
            to_q <= 1'b0;
         end else begin
            to_q <= 1'b0;
            if (!trk_en[i]) begin
               cnt  <= '0;
               done <= 1'b0;
            end else if (!done) begin
               if (trk_ok[i]) begin
                  done <= 1'b1;
               end else if (cnt == TW'(SETTLE_CYC - 1)) begin
                  done <= 1'b1;
                  to_q <= 1'b1;
               end else begin
                  cnt <= cnt + TW'(1);
               end
            end
         end
      end
      assign timeout[i] = to_q;
   end

   assign err_set = temp_warn | wd_err | (|cold_evt) | (|timeout);
   assign clr     = apply;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_l     <= 1'b0;
         wderr_l   <= 1'b0;
         cold_l    <= 2'b11;
         snap_err  <= 1'b0;
         snap_wd   <= 1'b0;
         snap_cold <= 2'b00;
      end else begin
         if (load) begin
            snap_err  <= err_l;
            snap_wd   <= wderr_l;
            snap_cold <= cold_l;
         end
         err_l   <= err_set | (err_l & ~(clr & snap_err));
         wderr_l <= wd_err | (wderr_l & ~(clr & snap_wd));
         cold_l  <= cold_evt | (cold_l & ~({2{clr}} & snap_cold));
      end
   end

   always_comb begin
      status_word              = '0;
      status_word[0]           = err_l;
      status_word[1]           = temp_warn;
      status_word[2 +: N_TRK]  = trk_en & trk_ok;
      status_word[9:8]         = ~cold_l;
      status_word[10]          = win_closed;
      status_word[13:11]       = rst_cond;
      status_word[14]          = wderr_l;
      status_word[15]          = conv_on;
   end

   assign err_flag = err_l;
endmodule

// File: rtl/spi_diag_reg.sv
module spi_diag_reg
   import spi_diag_pkg::*;
#(
   parameter int SETTLE_CYC = 125000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             spi_sclk,
   input  logic             spi_cs_n,
   input  logic             spi_mosi,
   output logic             spi_miso,
   output logic             spi_miso_oe,
   input  logic             wake,
   input  logic [N_TRK-1:0] trk_ok,
   input  logic             temp_warn,
   input  logic [1:0]       cold_evt,
   input  logic             win_closed,
   input  logic [2:0]       rst_cond,
   input  logic             wd_err,
   input  logic             conv_on,
   output logic [N_TRK-1:0] trk_en,
   output logic             power_down,
   output logic [1:0]       rst_dly,
   output logic [1:0]       wd_time,
   output logic             wd_en,
   output logic             wd_trig,
   output logic             err_flag
);
   if (SETTLE_CYC < 2) begin : g_bad_settle
      $error("SETTLE_CYC must be at least 2");
   end
   if (N_TRK + 2 > 8) begin : g_bad_trk
      $error("tracker field overlaps sleep bit");
   end

   logic              frame_load, frame_apply;
   logic [WORD_W-1:0] rx_word, status_word;

   spi_diag_shift #(.W(WORD_W)) u_shift (
      .clk        (clk),
      .rst_n      (rst_n),
      .sclk       (spi_sclk),
      .cs_n       (spi_cs_n),
      .mosi       (spi_mosi),
      .load_word  (status_word),
      .miso       (spi_miso),
      .miso_oe    (spi_miso_oe),
      .load_pulse (frame_load),
      .apply_pulse(frame_apply),
      .rx_word    (rx_word)
   );

   spi_diag_ctrl u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .apply     (frame_apply),
      .rx_word   (rx_word),
      .wake      (wake),
      .trk_en    (trk_en),
      .power_down(power_down),
      .rst_dly   (rst_dly),
      .wd_time   (wd_time),
      .wd_en     (wd_en),
      .wd_trig   (wd_trig)
   );

   spi_diag_stat #(.SETTLE_CYC(SETTLE_CYC)) u_stat (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (frame_load),
      .apply      (frame_apply),
      .trk_en     (trk_en),
      .trk_ok     (trk_ok),
      .temp_warn  (temp_warn),
      .cold_evt   (cold_evt),
      .win_closed (win_closed),
      .rst_cond   (rst_cond),
      .wd_err     (wd_err),
      .conv_on    (conv_on),
      .status_word(status_word),
      .err_flag   (err_flag)
   );
endmodule

// File: rtl/spi_diag_reg_chk.sv
module spi_diag_reg_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       spi_cs_n,
   input logic       spi_miso_oe,
   input logic       power_down,
   input logic       wake,
   input logic       wd_trig,
   input logic       wd_err,
   input logic       err_flag,
   input logic [5:0] trk_en,
   input logic       apply
);
   assert_oe_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $past(spi_cs_n, 2) |-> !spi_miso_oe);

   assert_ctrl_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !apply |=> $stable(trk_en));

   assert_wderr_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wd_err |=> err_flag);

   assert_err_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(err_flag) |-> $past(apply));

   assert_sleep_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
      power_down |-> !wake);

   assert_trig_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
      wd_trig |=> !wd_trig);
endmodule

bind spi_diag_reg spi_diag_reg_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .spi_cs_n   (spi_cs_n),
   .spi_miso_oe(spi_miso_oe),
   .power_down (power_down),
   .wake       (wake),
   .wd_trig    (wd_trig),
   .wd_err     (wd_err),
   .err_flag   (err_flag),
   .trk_en     (trk_en),
   .apply      (frame_apply)
);

// File: tb/spi_diag_reg_tb.sv
module spi_diag_reg_tb;
   localparam int HALF = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
   logic miso, miso_oe;
   logic wake = 1'b0;
   logic [5:0] trk_ok = 6'b111111;
   logic temp_warn = 1'b0;
   logic [1:0] cold_evt = 2'b00;
   logic win_closed = 1'b1;
   logic [2:0] rst_cond = 3'b101;
   logic wd_err = 1'b0;
   logic conv_on = 1'b1;
   logic [5:0] trk_en;
   logic power_down, wd_en, wd_trig, err_flag;
   logic [1:0] rst_dly, wd_time;

   int checks = 0;
   int fails = 0;
   int trig_cnt = 0;
   logic [31:0] rx;

   always #4 clk = ~clk;

   spi_diag_reg #(.SETTLE_CYC(40)) u_dut (
      .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
      .spi_miso(miso), .spi_miso_oe(miso_oe), .wake(wake), .trk_ok(trk_ok),
      .temp_warn(temp_warn), .cold_evt(cold_evt), .win_closed(win_closed),
      .rst_cond(rst_cond), .wd_err(wd_err), .conv_on(conv_on), .trk_en(trk_en),
      .power_down(power_down), .rst_dly(rst_dly), .wd_time(wd_time),
      .wd_en(wd_en), .wd_trig(wd_trig), .err_flag(err_flag)
   );

   always @(posedge clk) if (wd_trig) trig_cnt <= trig_cnt + 1;

   // word, trk_en, rst_dly, wd_time, wd_en, power_down (wake low)
   localparam logic [27:0] VEC [6] = '{
      {16'h4301, 6'b000000, 2'b00, 2'b00, 1'b1, 1'b0},
      {16'h0300, 6'b000000, 2'b00, 2'b00, 1'b0, 1'b0},
      {16'h2700, 6'b000000, 2'b01, 2'b10, 1'b0, 1'b0},
      {16'h1904, 6'b000001, 2'b10, 2'b01, 1'b1, 1'b0},
      {16'h00A8, 6'b101010, 2'b00, 2'b00, 1'b1, 1'b1},
      {16'h7DFC, 6'b111111, 2'b11, 2'b11, 1'b1, 1'b0}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic frame(input logic [31:0] tx, input int nbits, output logic [31:0] got);
      got = '0;
      cs_n = 1'b0;
      cyc(HALF);
      for (int i = 0; i < nbits; i++) begin
         mosi = tx[i];
         sclk = 1'b1;
         cyc(HALF);
         got[i] = miso;
         sclk = 1'b0;
         cyc(HALF);
      end
      cs_n = 1'b1;
      cyc(4 * HALF);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      cyc(5);
      rst_n = 1'b1;
      cyc(3);
      // R1 reset state
      chk("R1 trk_en", 32'(trk_en), 32'h0);
      chk("R1 power_down", 32'(power_down), 32'h0);
      chk("R1 wd_en", 32'(wd_en), 32'h1);
      chk("R1 codes", 32'({rst_dly, wd_time}), 32'h0);
      chk("R1 err_flag", 32'(err_flag), 32'h0);
      chk("R1 miso_oe", 32'(miso_oe), 32'h0);

      // R3 R4 first readout: cold flags set, live fields
      cs_n = 1'b0;
      cyc(4);
      chk("R3 oe while selected", 32'(miso_oe), 32'h1);
      cs_n = 1'b1;
      cyc(4 * HALF);
      frame(32'h4301, 16, rx);
      chk("R4 first status word", rx[15:0], 32'hAC00);

      // R2 R11 R10 table of control words
      for (int i = 0; i < 6; i++) begin
         frame(32'(VEC[i][27:12]), 16, rx);
         chk("R2 trk_en", 32'(trk_en), 32'(VEC[i][11:6]));
         chk("R2 rst_dly", 32'(rst_dly), 32'(VEC[i][5:4]));
         chk("R2 wd_time", 32'(wd_time), 32'(VEC[i][3:2]));
         chk("R11 wd_en", 32'(wd_en), 32'(VEC[i][1]));
         chk("R10 power_down", 32'(power_down), 32'(VEC[i][0]));
      end

      // R13 tracker status with all enabled
      trk_ok = 6'b010101;
      frame(32'h4301, 16, rx);
      chk("R13 tracker status", rx[15:0], 32'hAF54);
      chk("R7 cold flags cleared", 32'(rx[9:8]), 32'h3);

      // R8 R9 settle timeout
      trk_ok = 6'b111110;
      frame(32'h4305, 16, rx);
      cyc(100);
      chk("R8 timeout sets err pin", 32'(err_flag), 32'h1);
      frame(32'h4301, 16, rx);
      chk("R8 error bit read", rx[15:0], 32'hAF01);
      chk("R9 err pin cleared", 32'(err_flag), 32'h0);
      frame(32'h4301, 16, rx);
      chk("R7 error latch cleared", rx[15:0], 32'hAF00);

      // R7 watchdog error latched
      trk_ok = 6'b111111;
      wd_err = 1'b1;
      cyc(1);
      wd_err = 1'b0;
      cyc(2);
      chk("R8 wd_err sets pin", 32'(err_flag), 32'h1);
      frame(32'h4301, 16, rx);
      chk("R7 wd error latched", rx[15:0], 32'hEF01);
      frame(32'h4301, 16, rx);
      chk("R7 wd error cleared", rx[15:0], 32'hAF00);

      // R7 live vs latched with temperature warning
      temp_warn = 1'b1;
      cyc(3);
      frame(32'h4301, 16, rx);
      chk("R7 temp live and latched", rx[15:0], 32'hAF03);
      temp_warn = 1'b0;
      cyc(3);
      frame(32'h4301, 16, rx);
      chk("R7 temp live dropped", rx[15:0], 32'hAF01);
      frame(32'h4301, 16, rx);
      chk("R7 all clear", rx[15:0], 32'hAF00);

      // R8 cold-start event on rail 2
      cold_evt = 2'b10;
      cyc(1);
      cold_evt = 2'b00;
      cyc(2);
      frame(32'h4301, 16, rx);
      chk("R8 cold event", rx[15:0], 32'hAD01);
      frame(32'h4301, 16, rx);

      // R5 short frame ignored
      frame(32'hFC, 8, rx);
      chk("R5 short frame", 32'(trk_en), 32'h0);

      // R6 daisy chain 24 bits
      frame(32'h1904A5, 24, rx);
      chk("R6 last word applied", 32'({trk_en, rst_dly, wd_time}), 32'({6'b000001, 2'b10, 2'b01}));
      chk("R6 pass-through", 32'(rx[23:16]), 32'hA5);

      // R10 wake gating
      wake = 1'b1;
      frame(32'h0000, 16, rx);
      chk("R10 wake blocks", 32'(power_down), 32'h0);
      wake = 1'b0;
      cyc(2);
      chk("R10 sleep with wake low", 32'(power_down), 32'h1);

      // R12 trigger pulse
      trig_cnt = 0;
      frame(32'hC301, 16, rx);
      chk("R12 single trigger", 32'(trig_cnt), 32'h1);
      frame(32'h4301, 16, rx);
      chk("R12 no trigger", 32'(trig_cnt), 32'h1);

      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule